// File: doc/BRIEF.md
# Configurable UART frame receiver

This block recovers asynchronous serial frames from a single line that is oversampled by the system clock. The line passes through a synchroniser. Each frame then begins when an edge from the idle level to the active level is seen. From that point every bit slot is sampled once, at a programmable fraction of the bit time. The data bits are assembled into a word of up to nine bits. The optional parity slot and the optional stop slot are checked as the frame is received.

Software or a neighbouring block sets the receiver through static configuration inputs: the bit time in clock cycles, the data width, the parity rule, whether a stop slot exists, the bit order, line inversion and the sample-point percentage. Each received word is presented for one cycle on a strobe, together with a held validity flag and single-cycle error pulses. After a frame's final sample the receiver ignores the line until the nominal end of that frame, so disturbance late in the last bit time cannot start a new frame.

Top module: `uart_frame_rx`

## Requirements
- R1: After reset, data_o, data_valid_o, frame_ok_o, frame_err_o and parity_err_o are all 0.
- R2: data_bits_i selects 5 to 9 data bits; a value below 5 acts as 5 and a value above 9 acts as 9. data_o bits at and above the selected width are 0.
- R3: With msb_first_i = 0 the first data bit received lands in data_o[0]; with msb_first_i = 1 the first data bit received lands in data_o[width-1].
- R4: parity_mode_i encodes 0 none (no parity slot), 1 odd, 2 even, 3 forced zero, 4 forced one, 5 ignore (slot present, always passes); 6 and 7 act as none. Odd passes when the ones in the data bits plus the parity bit total an odd number, and even passes when the total is even.
- R5: A failed parity check raises parity_err_o for exactly the cycle that data_valid_o is high, and frame_ok_o is 0 for that word.
- R6: With stop_en_i = 1, a stop slot read as 0 raises frame_err_o together with data_valid_o; the word is still delivered and frame_ok_o is 0. With stop_en_i = 0 no stop slot is sampled.
- R7: A start slot read as the idle level at its sample point raises frame_err_o for one cycle without data_valid_o, and the receiver returns to waiting for a start edge.
- R8: With invert_i = 0 the line idles high and a falling edge starts a frame; with invert_i = 1 the line idles low, a rising edge starts a frame, and every bit is read inverted.
- R9: Slot k is sampled k*C + floor((C-1)*p/100) cycles after the start edge is detected, with C = clks_per_bit_i and p = sample_pct_i; a p outside 1 to 99 acts as 50.
- R10: From the last sample of a frame until the nominal end of that frame, start edges are ignored.
- R11: data_valid_o is high for exactly one cycle per delivered word. data_o and frame_ok_o hold their values until the next word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_i | input | 1 | Asynchronous serial line |
| clks_per_bit_i | input | CPB_W | Bit time in clock cycles |
| data_bits_i | input | 4 | Data width, 5 to 9 |
| parity_mode_i | input | 3 | Parity rule (encoding in R4) |
| stop_en_i | input | 1 | A stop slot follows data/parity |
| msb_first_i | input | 1 | First data bit is the most significant |
| invert_i | input | 1 | Line idles low and is read inverted |
| sample_pct_i | input | 7 | Sample point in percent of a bit time |
| data_o | output | DATA_MAX | Last received word, zero-extended |
| data_valid_o | output | 1 | One-cycle strobe for a new word |
| frame_ok_o | output | 1 | Last word had no parity or stop fault |
| frame_err_o | output | 1 | Pulse on bad start or stop slot |
| parity_err_o | output | 1 | Pulse on parity mismatch |

## Verification
The bench builds the block with its default parameters: a 16-bit bit-time counter, nine-bit maximum words and two synchroniser stages. It drives bit times of 16 and 5 cycles, which reach the full nine-bit width, every parity rule and the clamping of out-of-range widths. Short low pulses with sample points of 10 and 50 percent separate a spurious start from a real one. A pulse placed after the stop sample reaches the late-frame hold-off window.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    typedef enum logic [2:0] {
        PAR_NONE   = 3'd0,
        PAR_ODD    = 3'd1,
        PAR_EVEN   = 3'd2,
        PAR_ZERO   = 3'd3,
        PAR_ONE    = 3'd4,
        PAR_IGNORE = 3'd5
    } parity_mode_e;

    typedef enum logic [1:0] {
        ST_HUNT = 2'd0,
        ST_SLOT = 2'd1,
        ST_HOLD = 2'd2
    } rx_state_e;

    localparam int DATA_MIN    = 5;
    localparam int PCT_DEFAULT = 50;

endpackage

// File: rtl/uart_rx_line_sync.sv
module uart_rx_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    input  logic invert_i,
    output logic level_o,
    output logic fall_o
);

    logic [STAGES-1:0] sync_d, sync_q;
    logic              prev_d, prev_q;

    // Inversion before the chain keeps the logical idle level at 1.
    always_comb begin
        sync_d = {sync_q[STAGES-2:0], raw_i ^ invert_i};
        prev_d = sync_q[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
            prev_q <= 1'b1;
        end else begin
            sync_q <= sync_d;
            prev_q <= prev_d;
        end
    end

    assign level_o = sync_q[STAGES-1];
    assign fall_o  = prev_q & ~sync_q[STAGES-1];

endmodule

// File: rtl/uart_rx_sample_offset.sv
module uart_rx_sample_offset #(
    parameter int CPB_W = 16,
    parameter int PCT_W = 7
) (
    input  logic [CPB_W-1:0] cpb_i,
    input  logic [PCT_W-1:0] pct_i,
    output logic [CPB_W-1:0] cpb_m1_o,
    output logic [CPB_W-1:0] offset_o
);
    import uart_rx_pkg::*;

    localparam int PROD_W = CPB_W + PCT_W;

    logic [PCT_W-1:0]  pct_eff;
    logic [PROD_W-1:0] prod;
    logic [PROD_W-1:0] quot;

    always_comb begin
        if (pct_i >= PCT_W'(1) && pct_i <= PCT_W'(99)) begin
            pct_eff = pct_i;
        end else begin
            pct_eff = PCT_W'(PCT_DEFAULT);
        end
        cpb_m1_o = (cpb_i == '0) ? '0 : cpb_i - CPB_W'(1);
        prod     = PROD_W'(cpb_m1_o) * PROD_W'(pct_eff);
        quot     = prod / PROD_W'(100);
        offset_o = CPB_W'(quot);
    end

    always_comb begin
        AST_OFFSET_IN_BIT: assert (offset_o <= cpb_m1_o); // R9
    end

endmodule

// File: rtl/uart_rx_parity_check.sv
module uart_rx_parity_check #(
    parameter int DATA_W = 9
) (
    input  logic [DATA_W-1:0] data_i,
    input  logic              pbit_i,
    input  logic [2:0]        mode_i,
    output logic              ok_o
);
    import uart_rx_pkg::*;

    logic odd_total;

    always_comb begin
        odd_total = (^data_i) ^ pbit_i;
        case (mode_i)
            PAR_ODD:  ok_o = odd_total;
            PAR_EVEN: ok_o = ~odd_total;
            PAR_ZERO: ok_o = ~pbit_i;
            PAR_ONE:  ok_o = pbit_i;
            default:  ok_o = 1'b1;
        endcase
    end

endmodule

// File: rtl/uart_frame_rx.sv
module uart_frame_rx #(
    parameter int CPB_W       = 16,
    parameter int DATA_MAX    = 9,
    parameter int PCT_W       = 7,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                line_i,
    input  logic [CPB_W-1:0]    clks_per_bit_i,
    input  logic [3:0]          data_bits_i,
    input  logic [2:0]          parity_mode_i,
    input  logic                stop_en_i,
    input  logic                msb_first_i,
    input  logic                invert_i,
    input  logic [PCT_W-1:0]    sample_pct_i,
    output logic [DATA_MAX-1:0] data_o,
    output logic                data_valid_o,
    output logic                frame_ok_o,
    output logic                frame_err_o,
    output logic                parity_err_o
);
    import uart_rx_pkg::*;

    localparam int SLOT_W = $clog2(DATA_MAX + 4);

    typedef struct packed {
        rx_state_e           st;
        logic [CPB_W-1:0]    cnt;
        logic [SLOT_W-1:0]   slot;
        logic [DATA_MAX-1:0] word;
        logic                par_bad;
        logic [DATA_MAX-1:0] data;
        logic                valid;
        logic                ok;
        logic                ferr;
        logic                perr;
    } rx_regs_t;

    rx_regs_t r_d, r_q;

    logic             level, fall;
    logic [CPB_W-1:0] cpb_m1, offset;
    logic             par_ok;
    logic [3:0]       eff_width;
    logic             par_en;
    logic [SLOT_W-1:0] data_last, par_slot, last_slot, pos;
    logic [DATA_MAX-1:0] word_upd;
    logic             finish, perr_now, stop_bad;

    uart_rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw_i    (line_i),
        .invert_i (invert_i),
        .level_o  (level),
        .fall_o   (fall)
    );

    uart_rx_sample_offset #(.CPB_W(CPB_W), .PCT_W(PCT_W)) u_offset (
        .cpb_i    (clks_per_bit_i),
        .pct_i    (sample_pct_i),
        .cpb_m1_o (cpb_m1),
        .offset_o (offset)
    );

    // The word is complete in r_q by the time the parity slot is sampled.
    uart_rx_parity_check #(.DATA_W(DATA_MAX)) u_parity (
        .data_i (r_q.word),
        .pbit_i (level),
        .mode_i (parity_mode_i),
        .ok_o   (par_ok)
    );

    // Frame geometry derived from the configuration.
    always_comb begin
        if (data_bits_i < 4'(DATA_MIN)) begin
            eff_width = 4'(DATA_MIN);
        end else if (data_bits_i > 4'(DATA_MAX)) begin
            eff_width = 4'(DATA_MAX);
        end else begin
            eff_width = data_bits_i;
        end
        par_en    = (parity_mode_i >= 3'(PAR_ODD)) && (parity_mode_i <= 3'(PAR_IGNORE));
        data_last = SLOT_W'(eff_width);
        par_slot  = data_last + SLOT_W'(1);
        last_slot = data_last + SLOT_W'(par_en) + SLOT_W'(stop_en_i);
        if (msb_first_i) begin
            pos = data_last - r_q.slot;
        end else begin
            pos = r_q.slot - SLOT_W'(1);
        end
    end

    always_comb begin
        r_d       = r_q;
        r_d.valid = 1'b0;
        r_d.ferr  = 1'b0;
        r_d.perr  = 1'b0;
        word_upd  = r_q.word;
        finish    = 1'b0;
        perr_now  = r_q.par_bad;
        stop_bad  = 1'b0;

        unique case (r_q.st)
            ST_HUNT: begin
                if (fall) begin
                    r_d.st      = ST_SLOT;
                    r_d.cnt     = offset;
                    r_d.slot    = '0;
                    r_d.word    = '0;
                    r_d.par_bad = 1'b0;
                end
            end
            ST_SLOT: begin
                if (r_q.cnt == '0) begin
                    r_d.cnt = cpb_m1;
                    if (r_q.slot == '0) begin
                        if (level) begin
                            r_d.ferr = 1'b1;
                            r_d.st   = ST_HUNT;
                        end else begin
                            r_d.slot = SLOT_W'(1);
                        end
                    end else begin
                        if (r_q.slot <= data_last) begin
                            for (int i = 0; i < DATA_MAX; i++) begin
                                if (pos == SLOT_W'(i)) begin
                                    word_upd[i] = level;
                                end
                            end
                        end else if (par_en && (r_q.slot == par_slot)) begin
                            r_d.par_bad = ~par_ok;
                            perr_now    = ~par_ok;
                        end else begin
                            stop_bad = ~level;
                        end
                        r_d.word = word_upd;
                        if (r_q.slot == last_slot) begin
                            finish = 1'b1;
                        end else begin
                            r_d.slot = r_q.slot + SLOT_W'(1);
                        end
                    end
                end else begin
                    r_d.cnt = r_q.cnt - CPB_W'(1);
                end
            end
            ST_HOLD: begin
                if (r_q.cnt == '0) begin
                    r_d.st = ST_HUNT;
                end else begin
                    r_d.cnt = r_q.cnt - CPB_W'(1);
                end
            end
            default: begin
                r_d.st = ST_HUNT;
            end
        endcase

        if (finish) begin
            r_d.valid = 1'b1;
            r_d.data  = word_upd;
            r_d.perr  = perr_now;
            r_d.ferr  = stop_bad;
            r_d.ok    = ~(perr_now | stop_bad);
            r_d.st    = ST_HOLD;
            r_d.cnt   = cpb_m1 - offset;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign data_o       = r_q.data;
    assign data_valid_o = r_q.valid;
    assign frame_ok_o   = r_q.ok;
    assign frame_err_o  = r_q.ferr;
    assign parity_err_o = r_q.perr;

    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid_o |=> !data_valid_o); // R11

    AST_PERR_WITH_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        parity_err_o |-> data_valid_o); // R5

    AST_NO_PERR_WITHOUT_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        (data_valid_o && !par_en) |-> !parity_err_o); // R4

    AST_WORD_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid_o |-> ((data_o >> eff_width) == '0)); // R2

    AST_HOLD_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_HOLD) |=> (r_q.st != ST_SLOT)); // R10

endmodule

// File: tb/uart_frame_rx_bench.sv
module uart_frame_rx_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line_i = 1'b1;
    logic [15:0] cpb = 16'd16;
    logic [3:0] cfg_width = 4'd8;
    logic [2:0] cfg_pm = 3'd0;
    logic       cfg_stop = 1'b1;
    logic       cfg_msb = 1'b0;
    logic       cfg_inv = 1'b0;
    logic [6:0] cfg_pct = 7'd50;

    logic [8:0] data_o;
    logic       data_valid_o, frame_ok_o, frame_err_o, parity_err_o;

    int tests = 0;
    int fails = 0;
    int vcnt = 0;
    int lone_ferr = 0;
    logic [8:0] got_data = '0;
    logic got_ok = 0, got_ferr = 0, got_perr = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    uart_frame_rx u_uart_frame_rx (
        .clk            (clk),
        .rst_n          (rst_n),
        .line_i         (line_i),
        .clks_per_bit_i (cpb),
        .data_bits_i    (cfg_width),
        .parity_mode_i  (cfg_pm),
        .stop_en_i      (cfg_stop),
        .msb_first_i    (cfg_msb),
        .invert_i       (cfg_inv),
        .sample_pct_i   (cfg_pct),
        .data_o         (data_o),
        .data_valid_o   (data_valid_o),
        .frame_ok_o     (frame_ok_o),
        .frame_err_o    (frame_err_o),
        .parity_err_o   (parity_err_o)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (data_valid_o) begin
                vcnt     <= vcnt + 1;
                got_data <= data_o;
                got_ok   <= frame_ok_o;
                got_ferr <= frame_err_o;
                got_perr <= parity_err_o;
            end else if (frame_err_o) begin
                lone_ferr <= lone_ferr + 1;
            end
        end
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            fails = fails + 1;
            tests = tests + 1;
            $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cyc);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic check(input bit good, input string tag, input int act, input int exp);
        tests = tests + 1;
        if (!good) begin
            fails = fails + 1;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic lvl, input int n);
        line_i = lvl ^ cfg_inv;
        repeat (n) @(negedge clk);
    endtask

    task automatic send_frame(input logic [8:0] val, input int nb, input logic pflip,
                              input logic stopv);
        logic [8:0] m;
        logic pb;
        m = val & ((9'h1 << nb) - 9'h1);
        case (cfg_pm)
            3'd1: pb = ~(^m);
            3'd2: pb = ^m;
            3'd4: pb = 1'b1;
            default: pb = 1'b0;
        endcase
        drive(1'b0, cpb);
        for (int i = 0; i < nb; i++) begin
            drive(cfg_msb ? m[nb-1-i] : m[i], cpb);
        end
        if (cfg_pm >= 3'd1 && cfg_pm <= 3'd5) drive(pb ^ pflip, cpb);
        if (cfg_stop) drive(stopv, cpb);
        drive(1'b1, 2 * cpb);
    endtask

    // {width[27:24], pmode[23:21], msb[20], stop_en[19], inv[18], stop0[17], pflip[16], pct[15:9], data[8:0]}
    localparam logic [27:0] VEC [12] = '{
        {4'd8, 3'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 7'd50, 9'h0A5},
        {4'd8, 3'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 7'd50, 9'h01C},
        {4'd5, 3'd2, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 7'd50, 9'h013},
        {4'd9, 3'd1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 7'd50, 9'h1F3},
        {4'd7, 3'd1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 7'd50, 9'h055},
        {4'd6, 3'd3, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 7'd30, 9'h02A},
        {4'd8, 3'd4, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 7'd75, 9'h03C},
        {4'd8, 3'd5, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 7'd50, 9'h081},
        {4'd8, 3'd0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 7'd50, 9'h07E},
        {4'd8, 3'd2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 7'd50, 9'h096},
        {4'd9, 3'd0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 7'd0,  9'h101},
        {4'd8, 3'd3, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 7'd99, 9'h000}
    };

    initial begin
        int v0, f0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R1 reset state
        check({data_o, data_valid_o, frame_ok_o, frame_err_o, parity_err_o} == '0,
              "R1 reset", {data_o, data_valid_o, frame_ok_o, frame_err_o, parity_err_o}, 0);

        foreach (VEC[k]) begin
            logic [27:0] e;
            logic [8:0] exp_d;
            logic exp_perr, exp_ferr;
            int nb;
            e = VEC[k];
            @(negedge clk);
            cfg_inv   = e[18];
            line_i    = e[18];
            cfg_width = e[27:24];
            cfg_pm    = e[23:21];
            cfg_msb   = e[20];
            cfg_stop  = e[19];
            cfg_pct   = e[15:9];
            repeat (4) @(negedge clk);
            nb = int'(e[27:24]);
            exp_d    = e[8:0] & ((9'h1 << nb) - 9'h1);
            exp_perr = e[16] && (e[23:21] >= 3'd1) && (e[23:21] <= 3'd4);
            exp_ferr = e[19] && e[17];
            v0 = vcnt;
            send_frame(e[8:0], nb, e[16], ~e[17]);
            check(vcnt == v0 + 1, "R11 one strobe", vcnt - v0, 1);
            check(got_data == exp_d, e[18] ? "R8 data" : (e[20] ? "R3 data" : "R2 data"),
                  got_data, exp_d);
            check(got_perr == exp_perr, "R4 parity", got_perr, exp_perr);
            check(got_ferr == exp_ferr, "R6 stop", got_ferr, exp_ferr);
            check(got_ok == !(exp_perr || exp_ferr), "R5 ok", got_ok, !(exp_perr || exp_ferr));
            check(data_o == exp_d, "R11 held data", data_o, exp_d);
        end

        // Back to plain configuration
        @(negedge clk);
        cfg_inv = 0; line_i = 1; cfg_width = 8; cfg_pm = 0; cfg_msb = 0; cfg_stop = 1;
        cfg_pct = 50;
        repeat (40) @(negedge clk);

        // R7 spurious start: short low pulse, sampled high at 50 percent
        v0 = vcnt; f0 = lone_ferr;
        drive(1'b0, 4);
        drive(1'b1, 3 * 16);
        check(lone_ferr == f0 + 1, "R7 start error", lone_ferr - f0, 1);
        check(vcnt == v0, "R7 no data", vcnt - v0, 0);

        // R9 early sample point catches the same kind of pulse as a start
        cfg_pct = 10;
        repeat (4) @(negedge clk);
        v0 = vcnt;
        drive(1'b0, 5);
        drive(1'b1, 12 * 16);
        check(vcnt == v0 + 1, "R9 early sample count", vcnt - v0, 1);
        check(got_data == 9'h0FF && got_ok, "R9 early sample data", got_data, 9'h0FF);
        cfg_pct = 50;

        // R10 low pulse after the stop sample is ignored
        v0 = vcnt; f0 = lone_ferr;
        drive(1'b0, 16);
        for (int i = 0; i < 8; i++) drive(((9'h05A >> i) & 1) != 0, 16);
        drive(1'b1, 10);
        drive(1'b0, 3);
        drive(1'b1, 3 + 32);
        check(vcnt == v0 + 1 && got_data == 9'h05A, "R10 frame kept", got_data, 9'h05A);
        check(lone_ferr == f0, "R10 no retrigger", lone_ferr - f0, 0);
        check(data_o == 9'h05A, "R10 output untouched", data_o, 9'h05A);

        // R9 short bit time
        cpb = 16'd5;
        repeat (4) @(negedge clk);
        send_frame(9'h03C, 8, 1'b0, 1'b1);
        check(got_data == 9'h03C, "R9 five-cycle bit", got_data, 9'h03C);
        cpb = 16'd16;
        repeat (4) @(negedge clk);

        // R2 width clamping
        cfg_width = 4'd3;
        repeat (4) @(negedge clk);
        send_frame(9'h015, 5, 1'b0, 1'b1);
        check(got_data == 9'h015, "R2 clamp low", got_data, 9'h015);
        cfg_width = 4'd15;
        repeat (4) @(negedge clk);
        send_frame(9'h1AB, 9, 1'b0, 1'b1);
        check(got_data == 9'h1AB, "R2 clamp high", got_data, 9'h1AB);

        // R4 code 7 behaves as no parity slot
        cfg_width = 4'd8; cfg_pm = 3'd7;
        repeat (4) @(negedge clk);
        send_frame(9'h0C3, 8, 1'b0, 1'b1);
        check(got_data == 9'h0C3 && got_ok && !got_perr, "R4 code 7", got_data, 9'h0C3);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule